// File: doc/BRIEF.md
# Register-Offset Load/Store Unit

This block carries out one memory transfer per request, at an address that is the sum of two registers. A request carries a 3-bit operation code and three 3-bit register indices: one for the data register (destination of a load, source of a store), one for the base and one for the offset. All three index an internal eight-entry, 32-bit register file. The unit adds base and offset, drives a single-port, little-endian 32-bit data memory with byte enables, and returns loaded data to the data register. Halfword and byte loads are zero- or sign-extended.

An alignment check can be switched on at each request. When the check is on, a misaligned word or halfword transfer is refused: a fault is reported and neither memory nor the register file changes. When the check is off, misaligned transfers still complete with defined results. A store goes to the aligned-down halfword or word. A load returns the aligned-down word rotated by the byte offset, then cut to size and extended.

The unit accepts a new request only when idle, so requests are issued one at a time and the issuer waits for `done`.

Top module: `lsu_regoff_unit`

## Requirements
- R1: A `start` pulse in the idle state launches one operation. Opcodes are 0 word load, 1 word store, 2 unsigned halfword load, 3 signed halfword load, 4 halfword store, 5 unsigned byte load, 6 signed byte load and 7 byte store. Stores and refused transfers raise `done` for one cycle, in the cycle after `start`. Loads raise `done` one cycle later, and the data register takes `load_data` at the end of that cycle.
- R2: The effective address is base plus offset, modulo 2^32. `mem_addr` is the effective address with bits 1:0 cleared.
- R3: Unsigned halfword and byte loads place the value in the low 16 or 8 bits of the result and clear all upper bits.
- R4: Signed halfword and byte loads fill the upper bits of the result with bit 15 or bit 7 of the loaded value.
- R5: Stores write only the low bits of the data register, with the value repeated on every lane of `mem_wdata`. Byte enables are bit k for a byte at address offset k. For a halfword they are 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. For a word they are 4'b1111.
- R6: With `align_chk_en` high, byte transfers are never refused. A halfword is refused when address bit 0 is set, and a word is refused when address bits 1:0 are not zero.
- R7: A refused transfer raises `align_fault` together with `done` for one cycle. It never asserts `mem_en`, and it leaves the data register unchanged.
- R8: With the check off, a misaligned halfword store writes the halfword at the address with bit 0 cleared. A misaligned word store writes the word at the address with bits 1:0 cleared.
- R9: With the check off, a misaligned load returns the aligned-down word rotated right by 8 × address[1:0], then cut to size and extended as in R3 and R4.
- R10: Under reset `done`, `align_fault` and `mem_en` are low, and every register file entry reads as zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch request (taken only when idle) |
| op | input | 3 | Operation code (see R1) |
| rd_idx | input | 3 | Data register index |
| rn_idx | input | 3 | Base register index |
| rm_idx | input | 3 | Offset register index |
| align_chk_en | input | 1 | Refuse misaligned word/halfword transfers |
| done | output | 1 | Operation complete (one-cycle pulse) |
| align_fault | output | 1 | Transfer refused for misalignment |
| load_data | output | 32 | Formatted load result, valid with `done` of a load |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_be | output | 4 | Byte enables for writes |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write data, replicated across lanes |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |

## Verification
The register file starts at zero and can only be filled by loads. Reaching a useful base, a negative offset or a misaligned address therefore takes a chain of word loads from a preset memory: address 0 yields 4, 4 yields 16, and so on. The chain ends in a register holding -4, which makes the address addition wrap. The hardest case to observe is R7: it requires that a refused load leaves its destination register untouched. The stimulus first loads a known value into that register and then attempts refused loads into it. Finally it stores the register back to memory, where the scoreboard sees the original value on `mem_wdata`.

// File: rtl/lsu_pkg.sv
// Package: lsu_pkg
// Shared operation codes, transfer sizes and controller states for the
// register-offset load/store unit. Assumes a 3-bit opcode field.
package lsu_pkg;

    typedef enum logic [2:0] {
        OP_LDW  = 3'd0,
        OP_STW  = 3'd1,
        OP_LDHU = 3'd2,
        OP_LDHS = 3'd3,
        OP_STH  = 3'd4,
        OP_LDBU = 3'd5,
        OP_LDBS = 3'd6,
        OP_STB  = 3'd7
    } lsu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } lsu_size_e;

    typedef enum logic [1:0] {
        FSM_IDLE = 2'd0,
        FSM_ACC  = 2'd1,
        FSM_RESP = 2'd2
    } lsu_fsm_e;

    // Transfer size implied by an opcode
    function automatic lsu_size_e op_size(input lsu_op_e o);
        case (o)
            OP_LDW, OP_STW:           return SZ_WORD;
            OP_LDHU, OP_LDHS, OP_STH: return SZ_HALF;
            default:                  return SZ_BYTE;
        endcase
    endfunction

    // True for the three store opcodes
    function automatic logic op_is_store(input lsu_op_e o);
        return (o == OP_STW) || (o == OP_STH) || (o == OP_STB);
    endfunction

    // True for loads that sign-extend
    function automatic logic op_is_signed(input lsu_op_e o);
        return (o == OP_LDHS) || (o == OP_LDBS);
    endfunction

endpackage

// File: rtl/lsu_rf.sv
// Module: lsu_rf
// Register file with three combinational read ports (base, offset, store
// data) and one synchronous write port. Assumes a single writer per cycle.
module lsu_rf #(
    parameter int XLEN = 32,
    parameter int NREG = 8,
    parameter int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] rn_sel,
    input  logic [IDXW-1:0] rm_sel,
    input  logic [IDXW-1:0] rs_sel,
    output logic [XLEN-1:0] rn_val,
    output logic [XLEN-1:0] rm_val,
    output logic [XLEN-1:0] rs_val,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_sel,
    input  logic [XLEN-1:0] wr_val
);

    logic [XLEN-1:0] regs [NREG];

    // Clear every entry in reset, otherwise take the single write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_sel] <= wr_val;
        end
    end

    assign rn_val = regs[rn_sel];
    assign rm_val = regs[rm_sel];
    assign rs_val = regs[rs_sel];

endmodule

// File: rtl/lsu_agen.sv
// Module: lsu_agen
// Combinational address generation: adds base and offset, splits the sum
// into word address and lane offset, decides misalignment, and builds the
// byte enables and lane-replicated write data for stores.
// Assumes little-endian byte lanes and XLEN a power-of-two multiple of 16.
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int BEW   = XLEN / 8,
    parameter int LANEW = $clog2(BEW)
) (
    input  logic [XLEN-1:0]  base,
    input  logic [XLEN-1:0]  offset,
    input  logic [XLEN-1:0]  src,
    input  lsu_op_e          op,
    input  logic             chk_en,
    output logic [XLEN-1:0]  word_addr,
    output logic [LANEW-1:0] lane_off,
    output logic [BEW-1:0]   be,
    output logic [XLEN-1:0]  wdata,
    output logic             fault
);

    logic [XLEN-1:0] sum;
    lsu_size_e       sz;
    logic            misal;
    logic            is_st;

    assign sum       = base + offset;
    assign lane_off  = sum[LANEW-1:0];
    assign word_addr = {sum[XLEN-1:LANEW], {LANEW{1'b0}}};
    assign sz        = op_size(op);
    assign is_st     = op_is_store(op);

    // Misalignment depends on transfer size only
    always_comb begin
        case (sz)
            SZ_HALF: misal = sum[0];
            SZ_WORD: misal = |sum[LANEW-1:0];
            default: misal = 1'b0;
        endcase
    end

    assign fault = chk_en && misal;

    // One enable per byte lane, selected by size and lane offset
    for (genvar g = 0; g < BEW; g++) begin : g_lane
        localparam logic [LANEW-1:0] LANE = LANEW'(g);
        assign be[g] = is_st && ((sz == SZ_WORD) ||
                                 (sz == SZ_HALF && LANE[LANEW-1:1] == lane_off[LANEW-1:1]) ||
                                 (sz == SZ_BYTE && LANE == lane_off));
    end

    // Replicate the low bits of the source across all lanes
    always_comb begin
        case (sz)
            SZ_BYTE: wdata = {BEW{src[7:0]}};
            SZ_HALF: wdata = {(BEW/2){src[15:0]}};
            default: wdata = src;
        endcase
    end

endmodule

// File: rtl/lsu_ldfmt.sv
// Module: lsu_ldfmt
// Load formatter: rotates the returned word right by the lane offset, then
// truncates to the transfer size and zero- or sign-extends. The same path
// serves aligned and misaligned loads.
module lsu_ldfmt
    import lsu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int LANEW = $clog2(XLEN / 8)
) (
    input  logic [XLEN-1:0]  rdata,
    input  logic [LANEW-1:0] lane_off,
    input  lsu_op_e          op,
    output logic [XLEN-1:0]  result
);

    logic [XLEN-1:0]    rot;
    logic [LANEW+2:0]   shamt;
    logic               sgn;

    assign shamt = {lane_off, 3'b000};
    assign rot   = XLEN'({rdata, rdata} >> shamt);
    assign sgn   = op_is_signed(op);

    // Size-dependent truncation and extension
    always_comb begin
        case (op_size(op))
            SZ_BYTE: result = {{(XLEN-8){sgn & rot[7]}}, rot[7:0]};
            SZ_HALF: result = {{(XLEN-16){sgn & rot[15]}}, rot[15:0]};
            default: result = rot;
        endcase
    end

endmodule

// File: rtl/lsu_regoff_unit.sv
// Module: lsu_regoff_unit
// Top of the register-offset load/store unit. In the start cycle the
// register file is read, the address is formed and decoded, and the results
// are registered. The next cycle presents the access, or reports a fault.
// Loads finish one cycle later with write-back. Assumes memory read data is
// valid one cycle after mem_en with mem_we low.
module lsu_regoff_unit
    import lsu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREG  = 8,
    parameter int IDXW  = $clog2(NREG),
    parameter int BEW   = XLEN / 8,
    parameter int LANEW = $clog2(BEW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [IDXW-1:0] rd_idx,
    input  logic [IDXW-1:0] rn_idx,
    input  logic [IDXW-1:0] rm_idx,
    input  logic            align_chk_en,
    output logic            done,
    output logic            align_fault,
    output logic [XLEN-1:0] load_data,
    output logic            mem_en,
    output logic            mem_we,
    output logic [BEW-1:0]  mem_be,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata
);

    lsu_fsm_e         state;
    lsu_op_e          q_op;
    logic [IDXW-1:0]  q_rd;
    logic [LANEW-1:0] q_off;
    logic [XLEN-1:0]  q_addr;
    logic [BEW-1:0]   q_be;
    logic [XLEN-1:0]  q_wdata;
    logic             q_fault;

    logic [XLEN-1:0]  rn_val, rm_val, rs_val;
    logic [XLEN-1:0]  a_addr, a_wdata, fmt_out;
    logic [LANEW-1:0] a_off;
    logic [BEW-1:0]   a_be;
    logic             a_fault;
    logic             rf_we;
    logic             q_store;

    lsu_rf #(.XLEN(XLEN), .NREG(NREG), .IDXW(IDXW)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .rn_sel (rn_idx),
        .rm_sel (rm_idx),
        .rs_sel (rd_idx),
        .rn_val (rn_val),
        .rm_val (rm_val),
        .rs_val (rs_val),
        .wr_en  (rf_we),
        .wr_sel (q_rd),
        .wr_val (fmt_out)
    );

    lsu_agen #(.XLEN(XLEN), .BEW(BEW), .LANEW(LANEW)) u_agen (
        .base      (rn_val),
        .offset    (rm_val),
        .src       (rs_val),
        .op        (lsu_op_e'(op)),
        .chk_en    (align_chk_en),
        .word_addr (a_addr),
        .lane_off  (a_off),
        .be        (a_be),
        .wdata     (a_wdata),
        .fault     (a_fault)
    );

    lsu_ldfmt #(.XLEN(XLEN), .LANEW(LANEW)) u_fmt (
        .rdata    (mem_rdata),
        .lane_off (q_off),
        .op       (q_op),
        .result   (fmt_out)
    );

    assign q_store = op_is_store(q_op);

    // Sequencer: capture the decoded request, then access, then respond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FSM_IDLE;
            q_op    <= OP_LDW;
            q_rd    <= '0;
            q_off   <= '0;
            q_addr  <= '0;
            q_be    <= '0;
            q_wdata <= '0;
            q_fault <= 1'b0;
        end else begin
            case (state)
                FSM_IDLE: if (start) begin
                    state   <= FSM_ACC;
                    q_op    <= lsu_op_e'(op);
                    q_rd    <= rd_idx;
                    q_off   <= a_off;
                    q_addr  <= a_addr;
                    q_be    <= a_be;
                    q_wdata <= a_wdata;
                    q_fault <= a_fault;
                end
                FSM_ACC:  state <= (!q_fault && !q_store) ? FSM_RESP : FSM_IDLE;
                default:  state <= FSM_IDLE;
            endcase
        end
    end

    assign mem_en      = (state == FSM_ACC) && !q_fault;
    assign mem_we      = mem_en && q_store;
    assign mem_be      = mem_we ? q_be : '0;
    assign mem_addr    = q_addr;
    assign mem_wdata   = q_wdata;
    assign align_fault = (state == FSM_ACC) && q_fault;
    assign done        = ((state == FSM_ACC) && (q_fault || q_store)) || (state == FSM_RESP);
    assign rf_we       = (state == FSM_RESP);
    assign load_data   = fmt_out;

    // R1: completion is a single-cycle pulse
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: a response cycle always follows a read access
    p_resp_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FSM_RESP) |-> $past(mem_en && !mem_we));

    // R7: a refused transfer completes without touching memory or registers
    p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (done && !mem_en && !rf_we));

    // R5: a byte store enables exactly one lane
    p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && op_size(q_op) == SZ_BYTE) |-> ($countones(mem_be) == 1));

    // R8: a halfword store enables exactly two lanes, even when misaligned
    p_half_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && op_size(q_op) == SZ_HALF) |-> ($countones(mem_be) == 2));

    // R3: an unsigned byte load leaves upper result bits clear
    p_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && q_op == OP_LDBU) |-> (load_data[XLEN-1:8] == '0));

endmodule

// File: tb/tb_lsu_regoff_unit.sv
`timescale 1ns/1ps
module tb_lsu_regoff_unit;

    localparam logic [2:0] LDW = 3'd0, STW = 3'd1, LDHU = 3'd2, LDHS = 3'd3,
                           STH = 3'd4, LDBU = 3'd5, LDBS = 3'd6, STB = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [2:0]  rd_idx = '0, rn_idx = '0, rm_idx = '0;
    logic        align_chk_en = 1'b0;
    logic        done, align_fault, mem_en, mem_we;
    logic [31:0] load_data, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_be;

    always #2 clk = ~clk;

    lsu_regoff_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .rd_idx(rd_idx), .rn_idx(rn_idx), .rm_idx(rm_idx),
        .align_chk_en(align_chk_en), .done(done), .align_fault(align_fault),
        .load_data(load_data), .mem_en(mem_en), .mem_we(mem_we),
        .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    typedef struct {
        logic        is_load;
        logic        is_store;
        logic        fault;
        logic [31:0] data;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        int          lat;
        int          t0;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [31:0] mem [16];
    logic [31:0] ref_mem [16];
    logic [31:0] ref_rf [8];
    int          n_cmp = 0, n_bad = 0, cyc = 0;
    logic        saw_en = 1'b0, lw = 1'b0;
    logic [31:0] la = '0, lwd = '0;
    logic [3:0]  lb = '0;

    // Count clock edges for latency checks
    always @(posedge clk) cyc <= cyc + 1;

    // Data memory: registered read, byte-enabled write
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[5:2]];
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare on every completion
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_en) begin
                saw_en = 1'b1; la = mem_addr; lb = mem_be; lw = mem_we; lwd = mem_wdata;
            end
            if (done) begin
                if (q.size() == 0) begin
                    check(1'b0, "R1 unexpected done", 32'(done), 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cyc - e.t0 == e.lat, {e.tag, " R1 latency"}, 32'(cyc - e.t0), 32'(e.lat));
                    check(align_fault == e.fault, {e.tag, " fault flag"}, 32'(align_fault), 32'(e.fault));
                    if (e.fault) check(!saw_en, {e.tag, " R7 no access"}, 32'(saw_en), 32'd0);
                    if (e.is_load) begin
                        check(load_data == e.data, {e.tag, " load data"}, load_data, e.data);
                        check(la == e.addr && !lw, {e.tag, " R2 read address"}, la, e.addr);
                    end
                    if (e.is_store) begin
                        check(la == e.addr && lw, {e.tag, " R2 write address"}, la, e.addr);
                        check(lb == e.be, {e.tag, " R5 byte enables"}, 32'(lb), 32'(e.be));
                        for (int b = 0; b < 4; b++)
                            if (e.be[b])
                                check(lwd[8*b +: 8] == e.wdata[8*b +: 8], {e.tag, " R5 lane data"},
                                      32'(lwd[8*b +: 8]), 32'(e.wdata[8*b +: 8]));
                    end
                end
                saw_en = 1'b0;
            end
        end
    end

    // Driver: model the operation from the requirements, push, then launch
    task automatic run_op(input logic [2:0] o, input int rd, input int rn, input int rm,
                          input logic chk, input string tag);
        exp_t        e;
        logic [31:0] ea, w, rot, s;
        logic [63:0] dw;
        logic [1:0]  k;
        int          sz;
        logic        st, sg, mis;
        ea = ref_rf[rn] + ref_rf[rm];
        k  = ea[1:0];
        case (o)
            LDW, STW:        sz = 2;
            LDHU, LDHS, STH: sz = 1;
            default:         sz = 0;
        endcase
        st  = (o == STW) || (o == STH) || (o == STB);
        sg  = (o == LDHS) || (o == LDBS);
        mis = (sz == 1 && ea[0]) || (sz == 2 && k != 2'd0);
        e.fault    = chk && mis;
        e.is_store = st && !e.fault;
        e.is_load  = !st && !e.fault;
        e.addr     = {ea[31:2], 2'b00};
        e.lat      = e.is_load ? 2 : 1;
        e.tag      = tag;
        e.data     = '0; e.be = '0; e.wdata = '0;
        if (e.is_load) begin
            w   = ref_mem[ea[5:2]];
            dw  = {w, w} >> (8 * k);
            rot = dw[31:0];
            case (sz)
                0: e.data = {{24{sg & rot[7]}}, rot[7:0]};
                1: e.data = {{16{sg & rot[15]}}, rot[15:0]};
                default: e.data = rot;
            endcase
            ref_rf[rd] = e.data;
        end
        if (e.is_store) begin
            s = ref_rf[rd];
            case (sz)
                0: begin e.be = 4'b0001 << k; e.wdata = {4{s[7:0]}}; end
                1: begin e.be = ea[1] ? 4'b1100 : 4'b0011; e.wdata = {2{s[15:0]}}; end
                default: begin e.be = 4'hF; e.wdata = s; end
            endcase
            for (int b = 0; b < 4; b++)
                if (e.be[b]) ref_mem[ea[5:2]][8*b +: 8] = e.wdata[8*b +: 8];
        end
        e.t0 = cyc;
        q.push_back(e);
        start = 1'b1; op = o; rd_idx = 3'(rd); rn_idx = 3'(rn); rm_idx = 3'(rm); align_chk_en = chk;
        @(negedge clk);
        start = 1'b0;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i] = 32'hA500_0000 | (i * 32'h0001_0203);
        end
        mem[0] = 32'd4;         mem[1] = 32'd16;        mem[2] = 32'd1;
        mem[3] = 32'h1234_5678; mem[4] = 32'h8765_F3A1; mem[5] = 32'hFFFF_FFFC;
        mem[8] = 32'd3;
        for (int i = 0; i < 16; i++) ref_mem[i] = mem[i];
        for (int i = 0; i < 8; i++) ref_rf[i] = '0;

        repeat (3) @(negedge clk);
        check(!done && !align_fault && !mem_en, "R10 reset outputs", {29'd0, done, align_fault, mem_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Fill registers through a chain of word loads (R2, R10 base is zero)
        run_op(LDW, 1, 0, 0, 1'b0, "R10 zero base");
        run_op(LDW, 2, 1, 0, 1'b0, "R2 base+0");
        run_op(LDW, 3, 2, 0, 1'b0, "R1 word load");
        run_op(LDW, 4, 1, 1, 1'b0, "R2 base+offset");
        run_op(LDW, 5, 2, 1, 1'b0, "R1 word load");
        run_op(LDW, 6, 2, 2, 1'b0, "R1 word load");
        run_op(STW, 7, 1, 1, 1'b0, "R10 register cleared");

        // Extension of sub-word loads
        run_op(LDBU, 7, 2, 4, 1'b0, "R3 byte lane1");
        run_op(LDBS, 7, 2, 4, 1'b0, "R4 byte lane1");
        run_op(LDBS, 7, 2, 0, 1'b0, "R4 byte lane0");
        run_op(LDBU, 7, 2, 6, 1'b0, "R3 byte lane3");
        run_op(LDBS, 7, 2, 6, 1'b0, "R4 byte lane3");
        run_op(LDHU, 7, 2, 0, 1'b0, "R3 half low");
        run_op(LDHS, 7, 2, 0, 1'b0, "R4 half low");
        run_op(LDW,  7, 2, 5, 1'b0, "R2 wrap-around sum");

        // Alignment checking on
        run_op(LDW,  7, 2, 4, 1'b1, "R7 refused word load");
        run_op(LDHS, 7, 2, 4, 1'b1, "R6 refused half load");
        run_op(STW,  3, 2, 4, 1'b1, "R7 refused word store");
        run_op(STH,  3, 2, 4, 1'b1, "R6 refused half store");
        run_op(STW,  7, 1, 1, 1'b1, "R7 destination kept");
        run_op(LDBS, 7, 2, 6, 1'b1, "R6 byte never refused");
        run_op(LDHU, 7, 2, 0, 1'b1, "R6 aligned half");
        run_op(LDW,  7, 1, 0, 1'b1, "R6 aligned word");

        // Stores with checking off
        run_op(STB, 3, 2, 6, 1'b0, "R5 byte lane3");
        run_op(STB, 3, 2, 4, 1'b0, "R5 byte lane1");
        run_op(STH, 3, 4, 4, 1'b0, "R5 half upper");
        run_op(STH, 3, 1, 4, 1'b0, "R8 misaligned half");
        run_op(STW, 5, 2, 6, 1'b0, "R8 misaligned word");
        run_op(STW, 3, 2, 2, 1'b0, "R5 word");

        // Misaligned loads with checking off
        run_op(LDW,  7, 2, 4, 1'b0, "R9 word rot8");
        run_op(LDHS, 7, 2, 6, 1'b0, "R9 half rot24");
        run_op(LDHU, 7, 1, 4, 1'b0, "R9 half rot8");
        run_op(LDW,  7, 2, 6, 1'b0, "R9 word rot24");
        run_op(STW,  7, 0, 0, 1'b0, "R9 write-back");

        // Final memory image against the model
        for (int i = 0; i < 16; i++)
            check(mem[i] == ref_mem[i], "R8 memory image", mem[i], ref_mem[i]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule